// File: doc/BRIEF.md
# Receive word FIFO with 16-bit host readout

This block sits behind the deserializer and label filter of one serial receive channel. Each time the upstream logic presents a valid 32-bit word, the block stores it in a 32-entry first-in first-out buffer. A host with a 16-bit parallel bus reads each word in two halves. A read with the half-select line low returns the lower half of the oldest word. A read with half-select high returns the upper half and also removes that word from the buffer.

Three active-low flags tell the host how full the buffer is: data ready, half full and full. When the buffer is already full, a new word is not dropped. It replaces the most recently stored entry, so the newest data is always kept and the occupancy stays at 32.

The read data bus is registered. The value selected by a read appears on the cycle after the read enable is sampled, and it holds until the next read.

Top module: `rxq_host_fifo`

## Requirements
- R1: While the synchronous active-high reset is asserted, the buffer is emptied. On the following cycle `ready_n`, `half_n` and `full_n` are all 1 and `rd_data` is 0.
- R2: `ready_n` is 0 exactly when at least one word is held. It changes on the clock edge that stores or removes the word.
- R3: A read sampled with `rd_hi`=0 places word bits [15:0] of the head word on `rd_data` in the next cycle. A read with `rd_hi`=1 places bits [31:16] there. Bit 0 of the word is the first bit received.
- R4: `full_n` is 0 exactly when 32 words are held.
- R5: `half_n` is 0 exactly when 16 or more words are held.
- R6: A read with `rd_hi`=0 leaves the occupancy unchanged. A read with `rd_hi`=1 on a non-empty buffer removes the head word. Words leave in the order they arrived.
- R7: A valid word that arrives while 32 words are held, with no removal in the same cycle, replaces the newest stored word. The occupancy stays at 32.
- R8: A valid word and a removal in the same cycle leave the occupancy unchanged and store the new word at the tail. This includes the case where the buffer is full.
- R9: A read while the buffer is empty returns 0 on `rd_data` and changes no flag. When `rd_en` is low, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_vld | input | 1 | Strobe: a received word is valid this cycle |
| wr_word | input | 32 | Received word, bit 0 first on the line |
| rd_en | input | 1 | Host read strobe |
| rd_hi | input | 1 | Half select: 0 lower half, 1 upper half (upper removes the word) |
| rd_data | output | 16 | Registered read data |
| ready_n | output | 1 | Low while any word is held |
| full_n | output | 1 | Low while 32 words are held |
| half_n | output | 1 | Low while 16 or more words are held |

## Verification
The assertions assume that `wr_vld`, `rd_en` and `rd_hi` are clean synchronous levels, sampled once per clock. They also assume that a removal only ever meets a non-empty buffer or is ignored, so occupancy arithmetic never wraps. The stimulus drives every input on the falling edge, well away from the sampling edge. The random phases mix reads on an empty buffer, writes into a full buffer and simultaneous write-and-remove cycles. Each of these is a legal input, so the assumptions hold everywhere the assertions apply.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned N_HALF  = WORD_W / BUS_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BUS_W-1:0]  half_t;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_sel_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_vld,
  input  logic                       rd_en,
  input  logic                       rd_hi,
  output logic                       mem_we,
  output logic [$clog2(DEPTH)-1:0]   mem_waddr,
  output logic [$clog2(DEPTH)-1:0]   mem_raddr,
  output logic                       is_empty,
  output logic [$clog2(DEPTH):0]     occ,
  output logic [$clog2(DEPTH):0]     occ_nxt
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);

  logic [AW-1:0] head_q, tail_q, tail_prev;
  logic          pop, push_new, overwrite, full;

  assign full      = (occ == OCC_FULL);
  assign is_empty  = (occ == '0);
  assign pop       = rd_en & rd_hi & ~is_empty;
  assign push_new  = wr_vld & (~full | pop);
  assign overwrite = wr_vld & full & ~pop;
  assign tail_prev = tail_q - AW'(1);

  assign mem_we    = wr_vld;
  assign mem_waddr = overwrite ? tail_prev : tail_q;
  assign mem_raddr = head_q;

  always_comb begin
    occ_nxt = occ;
    case ({push_new, pop})
      2'b10:   occ_nxt = occ + CW'(1);
      2'b01:   occ_nxt = occ - CW'(1);
      default: occ_nxt = occ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      occ    <= '0;
    end else begin
      if (pop)      head_q <= head_q + AW'(1);
      if (push_new) tail_q <= tail_q + AW'(1);
      occ <= occ_nxt;
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  word_t                    wdata,
  input  logic                     re,
  input  logic                     sel_hi,
  input  logic                     empty,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output half_t                    rdata
);
  word_t mem [DEPTH];
  half_t half_words [N_HALF];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar h = 0; h < int'(N_HALF); h++) begin : g_split
    assign half_words[h] = mem[raddr][h*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      if (empty)                    rdata <= '0;
      else if (sel_hi == HALF_HI)   rdata <= half_words[1];
      else                          rdata <= half_words[0];
    end
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned HALF_LVL = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(DEPTH):0] occ_nxt,
  output logic                   ready_n,
  output logic                   full_n,
  output logic                   half_n
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HALF = CW'(HALF_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_n <= 1'b1;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      ready_n <= (occ_nxt == '0);
      full_n  <= (occ_nxt != LVL_FULL);
      half_n  <= (occ_nxt <  LVL_HALF);
    end
  end
endmodule

// File: rtl/rxq_host_fifo.sv
module rxq_host_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned HALF_LVL = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_vld,
  input  logic [31:0] wr_word,
  input  logic        rd_en,
  input  logic        rd_hi,
  output logic [15:0] rd_data,
  output logic        ready_n,
  output logic        full_n,
  output logic        half_n
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          mem_we, is_empty;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [AW:0]   occ, occ_nxt;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .rd_en(rd_en), .rd_hi(rd_hi),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
    .is_empty(is_empty), .occ(occ), .occ_nxt(occ_nxt)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(wr_word),
    .re(rd_en), .sel_hi(rd_hi), .empty(is_empty), .raddr(mem_raddr),
    .rdata(rd_data)
  );

  rxq_flags #(.DEPTH(DEPTH), .HALF_LVL(HALF_LVL)) u_flags (
    .clk(clk), .rst(rst), .occ_nxt(occ_nxt),
    .ready_n(ready_n), .full_n(full_n), .half_n(half_n)
  );
endmodule

// File: rtl/rxq_host_fifo_chk.sv
module rxq_host_fifo_chk #(
  parameter int unsigned DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_vld,
  input logic                   rd_en,
  input logic                   rd_hi,
  input logic [15:0]            rd_data,
  input logic                   ready_n,
  input logic                   full_n,
  input logic                   half_n,
  input logic [$clog2(DEPTH):0] occ
);
  assert_reset_flags_R1: assert property (@(posedge clk)
    rst |=> (ready_n && full_n && half_n && rd_data == 16'h0));

  assert_full_implies_half_R4: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !half_n);

  assert_half_implies_ready_R5: assert property (@(posedge clk) disable iff (rst)
    !half_n |-> !ready_n);

  assert_lo_read_keeps_occ_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hi && !wr_vld) |=> $stable(occ));

  assert_pop_decrements_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi && !ready_n && !wr_vld) |=> (occ == $past(occ) - 1'b1));

  assert_overwrite_stays_full_R7: assert property (@(posedge clk) disable iff (rst)
    (!full_n && wr_vld && !(rd_en && rd_hi)) |=> !full_n);

  assert_write_pop_keeps_occ_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && rd_en && rd_hi && !ready_n) |=> $stable(occ));

  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ready_n) |=> (rd_data == 16'h0));

  assert_idle_holds_data_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind rxq_host_fifo rxq_host_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_vld(wr_vld), .rd_en(rd_en), .rd_hi(rd_hi),
  .rd_data(rd_data), .ready_n(ready_n), .full_n(full_n), .half_n(half_n),
  .occ(occ)
);

// File: tb/rxq_host_fifo_tb.sv
`timescale 1ns/1ps
module rxq_host_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_vld = 1'b0;
  logic [31:0] wr_word = '0;
  logic        rd_en = 1'b0;
  logic        rd_hi = 1'b0;
  logic [15:0] rd_data;
  logic        ready_n, full_n, half_n;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] mq[$];
  logic [15:0] exp_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxq_host_fifo u_dut (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_word(wr_word),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data),
    .ready_n(ready_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int sz = mq.size();
    chk(req, "rd_data", 32'(rd_data), 32'(exp_data));
    chk("R2", "ready_n", 32'(ready_n), 32'(sz == 0));
    chk("R4", "full_n",  32'(full_n),  32'(sz != 32));
    chk("R5", "half_n",  32'(half_n),  32'(sz < 16));
  endtask

  // one cycle; called at a falling edge, returns at the next one
  task automatic step(input logic wv, input logic [31:0] w,
                      input logic re, input logic hi, input string req);
    int  sz = mq.size();
    bit  popped;
    wr_vld = wv; wr_word = w; rd_en = re; rd_hi = hi;
    if (re) exp_data = (sz == 0) ? 16'h0 : (hi ? mq[0][31:16] : mq[0][15:0]);
    popped = re && hi && (sz != 0);
    if (popped) void'(mq.pop_front());
    if (wv) begin
      if (sz == 32 && !popped) mq[31] = w;   // R7 overwrite newest
      else mq.push_back(w);
    end
    @(negedge clk);
    wr_vld = 0; rd_en = 0; rd_hi = 0;
    check_all(req);
  endtask

  function automatic logic [31:0] pat(input int i);
    return {16'(i * 16'h9e37 + 16'h1234), 16'(i ^ 16'h5a5a)};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // R9: empty reads of both halves
    step(0, 0, 1, 0, "R9");
    step(0, 0, 1, 1, "R9");
    step(0, 0, 0, 0, "R9");

    // fill to 32 then overwrite: flags cross 16 and 32 (R2 R4 R5 R7)
    for (int i = 0; i < 32; i++) step(1, pat(i), 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, pat(100 + i), 0, 0, "R7");

    // R6: repeated lower-half reads do not remove
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R6");
    // R8: write with removal while full
    step(1, pat(200), 1, 1, "R8");
    step(0, 0, 0, 0, "R9");

    // drain in pairs, checking order and halves (R3 R6)
    while (mq.size() > 0) begin
      step(0, 0, 1, 0, "R3");
      step(0, 0, 1, 1, "R3");
    end
    step(0, 0, 1, 1, "R9");

    // R8 at low occupancy
    step(1, pat(300), 0, 0, "R8");
    step(1, pat(301), 1, 1, "R8");
    step(0, 0, 1, 0, "R8");

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic wv = ($urandom % 100) < 52;
      logic re = ($urandom % 100) < 50;
      logic hi = $urandom % 2;
      step(wv, $urandom, re, hi, "R6");
    end

    // reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mq.delete(); exp_data = '0;
    check_all("R1");
    step(0, 0, 1, 0, "R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule